// File: doc/BRIEF.md
# Descriptor Ring Address Generator

This block produces the addresses a DMA engine needs while it walks a table of descriptors arranged as a ring. Software programs a base address, a gap length counted in 32-bit words, and a size select that makes each descriptor either 4 or 8 words long. While the engine is stopped, these settings are copied into shadow registers. When the engine starts, the current descriptor address is the word-aligned base.

On each fetch request, the block issues every word address of the current descriptor in ascending order, one per clock cycle. It marks the index of each word and flags the final one. On an advance strobe, the current address moves past the end of the descriptor and past the programmed gap. If the fetched descriptor carried its end-of-ring flag, the address instead returns to the base. The bus master and the decoding of descriptor fields belong to the surrounding engine.

Top module: `desc_ring_addr_gen`

## Requirements
- R1: While rst_n is low, word_valid and word_last are 0, word_idx is 0 and desc_addr is 0.
- R2: While stopped (run_en low), desc_addr follows cfg_base with bits [1:0] forced to 0, one clock after the input changes.
- R3: When fetch_req is seen in the ready state, word_valid is high for consecutive cycles starting the next cycle. The word addresses are desc_addr, desc_addr+4, and so on, and word_idx counts 0, 1, 2 and upward.
- R4: A descriptor is 4 words when cfg_alt_size was 0 at start and 8 words when it was 1. word_last is high only on the final word, and word_valid drops the cycle after it.
- R5: An advance without desc_eor moves desc_addr, one cycle later, to desc_addr + 4 x (descriptor words + cfg_skip).
- R6: With cfg_skip of 0, consecutive descriptors are contiguous: the step is 16 bytes for 4-word descriptors and 32 bytes for 8-word descriptors.
- R7: An advance with desc_eor set returns desc_addr to the aligned base captured at start.
- R8: Changes to cfg_base, cfg_skip and cfg_alt_size while run_en is high have no effect on the step, the wrap target or the word count.
- R9: advance and fetch_req are ignored while a word sequence is being issued. In the ready state, advance takes precedence over fetch_req.
- R10: Lowering run_en clears word_valid the next cycle and returns desc_addr to tracking the aligned cfg_base.
- R11: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Engine running; low means stopped and configuration is open |
| cfg_base | input | ADDR_W | Ring base address (bits [1:0] ignored) |
| cfg_skip | input | SKIP_W | Gap between descriptors, in 32-bit words |
| cfg_alt_size | input | 1 | 0: 4-word descriptors, 1: 8-word descriptors |
| fetch_req | input | 1 | Issue the word addresses of the current descriptor |
| advance | input | 1 | Move to the next descriptor |
| desc_eor | input | 1 | End-of-ring flag of the current descriptor, sampled with advance |
| desc_addr | output | ADDR_W | Current descriptor address |
| word_valid | output | 1 | word_addr holds a fetch address this cycle |
| word_addr | output | ADDR_W | Address of the descriptor word being fetched |
| word_idx | output | IDX_W | Index of that word within the descriptor |
| word_last | output | 1 | Final word of the descriptor |

## Verification
A corrupted shadow register does not show up until the next advance or fetch. At that point it appears as a wrong step in desc_addr, a wrong wrap target, or a sequence of the wrong length, and the bench compares each of these against its own address model. A stuck or miscounted word counter appears within one descriptor's worth of cycles as a missing or misplaced word_last, or as a word address that breaks the 4-byte stride. A sequencer that fails to leave the fetch state appears as an advance that is ignored after the sequence ends.

// File: rtl/drag_pkg.sv
package drag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_FETCH = 2'd2
    } ring_state_e;

    function automatic logic [63:0] align_word(input logic [63:0] a);
        return a & ~64'd3;
    endfunction

endpackage

// File: rtl/drag_cfg_shadow.sv
module drag_cfg_shadow #(
    parameter int ADDR_W = 32,
    parameter int SKIP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [SKIP_W-1:0] skip_in,
    input  logic              alt_in,
    output logic [ADDR_W-1:0] base_o,
    output logic [SKIP_W-1:0] skip_o,
    output logic              alt_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [SKIP_W-1:0] skip;
        logic              alt;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (capture) begin
            sh_d.base = base_in & ~ADDR_W'(3);
            sh_d.skip = skip_in;
            sh_d.alt  = alt_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign base_o = sh_q.base;
    assign skip_o = sh_q.skip;
    assign alt_o  = sh_q.alt;
endmodule

// File: rtl/drag_step_calc.sv
module drag_step_calc #(
    parameter int ADDR_W     = 32,
    parameter int SKIP_W     = 5,
    parameter int BASE_WORDS = 4,
    parameter int ALT_WORDS  = 8,
    parameter int CNT_W      = 4
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [SKIP_W-1:0] skip,
    input  logic              alt,
    input  logic              eor,
    output logic [CNT_W-1:0]  words,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int STRIDE_W = ((CNT_W > SKIP_W) ? CNT_W : SKIP_W) + 1;

    logic [STRIDE_W-1:0] stride_words;
    logic [ADDR_W-1:0]   stride_bytes;

    generate
        if (ALT_WORDS == BASE_WORDS) begin : g_fixed_size
            assign words = CNT_W'(BASE_WORDS);
        end else begin : g_sel_size
            assign words = alt ? CNT_W'(ALT_WORDS) : CNT_W'(BASE_WORDS);
        end
    endgenerate

    always_comb begin
        stride_words = STRIDE_W'(words) + STRIDE_W'(skip);
        stride_bytes = ADDR_W'(stride_words) << 2;
        next_addr    = eor ? base_addr : (cur_addr + stride_bytes);
    end
endmodule

// File: rtl/drag_word_seq.sv
module drag_word_seq #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              abort,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [IDX_W:0]    word_count,
    output logic              word_valid,
    output logic [ADDR_W-1:0] word_addr,
    output logic [IDX_W-1:0]  word_idx,
    output logic              word_last
);
    typedef struct packed {
        logic              valid;
        logic              last;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t sq_d, sq_q;
    logic [IDX_W:0] idx_plus2;

    always_comb begin
        sq_d      = sq_q;
        idx_plus2 = {1'b0, sq_q.idx} + (IDX_W+1)'(2);
        if (abort) begin
            sq_d.valid = 1'b0;
            sq_d.last  = 1'b0;
            sq_d.idx   = '0;
        end else if (launch) begin
            sq_d.valid = 1'b1;
            sq_d.idx   = '0;
            sq_d.addr  = start_addr;
            sq_d.last  = (word_count == (IDX_W+1)'(1));
        end else if (sq_q.valid) begin
            if (sq_q.last) begin
                sq_d.valid = 1'b0;
                sq_d.last  = 1'b0;
                sq_d.idx   = '0;
            end else begin
                sq_d.idx  = sq_q.idx + 1'b1;
                sq_d.addr = sq_q.addr + ADDR_W'(4);
                sq_d.last = (idx_plus2 == word_count);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign word_valid = sq_q.valid;
    assign word_addr  = sq_q.addr;
    assign word_idx   = sq_q.idx;
    assign word_last  = sq_q.last;
endmodule

// File: rtl/desc_ring_addr_gen.sv
module desc_ring_addr_gen
    import drag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SKIP_W     = 5,
    parameter int BASE_WORDS = 4,
    parameter int ALT_WORDS  = 8,
    parameter int IDX_W      = $clog2(ALT_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SKIP_W-1:0] cfg_skip,
    input  logic              cfg_alt_size,
    input  logic              fetch_req,
    input  logic              advance,
    input  logic              desc_eor,
    output logic [ADDR_W-1:0] desc_addr,
    output logic              word_valid,
    output logic [ADDR_W-1:0] word_addr,
    output logic [IDX_W-1:0]  word_idx,
    output logic              word_last
);
    localparam int CNT_W = IDX_W + 1;

    typedef struct packed {
        ring_state_e       state;
        logic [ADDR_W-1:0] desc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              capture;
    logic              launch;
    logic              abort;
    logic [ADDR_W-1:0] sh_base;
    logic [SKIP_W-1:0] sh_skip;
    logic              sh_alt;
    logic [CNT_W-1:0]  desc_words;
    logic [ADDR_W-1:0] step_addr;
    logic [ADDR_W-1:0] base_aligned;

    assign base_aligned = cfg_base & ~ADDR_W'(3);
    assign capture      = (ctl_q.state == ST_IDLE);

    drag_cfg_shadow #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .base_in (cfg_base),
        .skip_in (cfg_skip),
        .alt_in  (cfg_alt_size),
        .base_o  (sh_base),
        .skip_o  (sh_skip),
        .alt_o   (sh_alt)
    );

    drag_step_calc #(
        .ADDR_W(ADDR_W), .SKIP_W(SKIP_W), .BASE_WORDS(BASE_WORDS),
        .ALT_WORDS(ALT_WORDS), .CNT_W(CNT_W)
    ) u_step (
        .cur_addr  (ctl_q.desc),
        .base_addr (sh_base),
        .skip      (sh_skip),
        .alt       (sh_alt),
        .eor       (desc_eor),
        .words     (desc_words),
        .next_addr (step_addr)
    );

    always_comb begin
        ctl_d  = ctl_q;
        launch = 1'b0;
        abort  = !run_en;
        if (!run_en) begin
            ctl_d.state = ST_IDLE;
            ctl_d.desc  = base_aligned;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE: begin
                    ctl_d.desc  = base_aligned;
                    ctl_d.state = ST_READY;
                end
                ST_READY: begin
                    if (advance) begin
                        ctl_d.desc = step_addr;
                    end else if (fetch_req) begin
                        ctl_d.state = ST_FETCH;
                        launch      = 1'b1;
                    end
                end
                ST_FETCH: begin
                    if (word_valid && word_last) ctl_d.state = ST_READY;
                end
                default: ctl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.desc  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    drag_word_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .abort      (abort),
        .start_addr (ctl_q.desc),
        .word_count (desc_words),
        .word_valid (word_valid),
        .word_addr  (word_addr),
        .word_idx   (word_idx),
        .word_last  (word_last)
    );

    assign desc_addr = ctl_q.desc;
endmodule

// File: rtl/drag_checker.sv
module drag_checker #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 3,
    parameter int BASE_WORDS = 4,
    parameter int ALT_WORDS  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [ADDR_W-1:0] desc_addr,
    input logic              word_valid,
    input logic [ADDR_W-1:0] word_addr,
    input logic [IDX_W-1:0]  word_idx,
    input logic              word_last
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!word_valid && !word_last)); // R1
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) (desc_addr[1:0] == 2'b00) && (word_addr[1:0] == 2'b00)); // R2
    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n) $rose(word_valid) |-> (word_addr == desc_addr && word_idx == '0)); // R3
    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n) (word_valid && !word_last && run_en) |=> (word_valid && word_addr == $past(word_addr) + ADDR_W'(4))); // R3
    AST_LAST_IDX: assert property (@(posedge clk) disable iff (!rst_n) word_last |-> (word_valid && (word_idx == IDX_W'(BASE_WORDS-1) || word_idx == IDX_W'(ALT_WORDS-1)))); // R4
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (word_valid && word_last) |=> !word_valid); // R4
    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (word_valid && run_en) |=> $stable(desc_addr)); // R9
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !run_en |=> !word_valid); // R10
endmodule

bind desc_ring_addr_gen drag_checker #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE_WORDS(BASE_WORDS), .ALT_WORDS(ALT_WORDS)
) u_drag_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .desc_addr  (desc_addr),
    .word_valid (word_valid),
    .word_addr  (word_addr),
    .word_idx   (word_idx),
    .word_last  (word_last)
);

// File: tb/desc_ring_addr_gen_test.sv
`timescale 1ns/1ps
module desc_ring_addr_gen_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [4:0]    cfg_skip = '0;
    logic          cfg_alt_size = 1'b0;
    logic          fetch_req = 1'b0;
    logic          advance = 1'b0;
    logic          desc_eor = 1'b0;
    logic [AW-1:0] desc_addr;
    logic          word_valid;
    logic [AW-1:0] word_addr;
    logic [2:0]    word_idx;
    logic          word_last;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [AW-1:0] exp_desc;
    logic [AW-1:0] exp_base;
    int            exp_words;
    int            exp_skip;

    always #10 clk = ~clk;

    desc_ring_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_base(cfg_base),
        .cfg_skip(cfg_skip), .cfg_alt_size(cfg_alt_size), .fetch_req(fetch_req),
        .advance(advance), .desc_eor(desc_eor), .desc_addr(desc_addr),
        .word_valid(word_valid), .word_addr(word_addr), .word_idx(word_idx),
        .word_last(word_last)
    );

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic test_reset();
        check(word_valid == 1'b0, "R1 word_valid", AW'(word_valid), 0);
        check(word_last == 1'b0, "R1 word_last", AW'(word_last), 0);
        check(word_idx == 3'd0, "R1 word_idx", AW'(word_idx), 0);
        check(desc_addr == '0, "R1 desc_addr", desc_addr, 0);
    endtask

    task automatic test_idle_track();
        cfg_base = 32'h2000_0006;
        tick();
        check(desc_addr == 32'h2000_0004, "R2 idle base align", desc_addr, 32'h2000_0004);
        cfg_base = 32'h0000_1003;
        tick();
        check(desc_addr == 32'h0000_1000, "R2 idle base follow", desc_addr, 32'h0000_1000);
    endtask

    task automatic start_ring(input logic [AW-1:0] base, input int skip, input bit alt);
        cfg_base = base;
        cfg_skip = 5'(skip);
        cfg_alt_size = alt;
        tick();
        run_en = 1'b1;
        tick();
        exp_base = base & ~32'd3;
        exp_desc = exp_base;
        exp_words = alt ? 8 : 4;
        exp_skip = skip;
        check(desc_addr == exp_desc, "R2 start at base", desc_addr, exp_desc);
    endtask

    task automatic fetch_desc(input bit inject);
        fetch_req = 1'b1;
        tick();
        fetch_req = 1'b0;
        for (int i = 0; i < exp_words; i++) begin
            check(word_valid == 1'b1, "R3 word_valid", AW'(word_valid), 1);
            check(word_addr == exp_desc + AW'(4*i), "R3 word_addr", word_addr, exp_desc + AW'(4*i));
            check(word_idx == 3'(i), "R3 word_idx", AW'(word_idx), AW'(i));
            check(word_last == (i == exp_words-1), "R4 word_last", AW'(word_last), AW'(i == exp_words-1));
            if (inject && i == 1) begin
                advance = 1'b1;
                fetch_req = 1'b1;
            end else begin
                advance = 1'b0;
                fetch_req = 1'b0;
            end
            tick();
        end
        advance = 1'b0;
        fetch_req = 1'b0;
        check(word_valid == 1'b0, "R4 word_valid drops", AW'(word_valid), 0);
        check(desc_addr == exp_desc, "R9 desc held during fetch", desc_addr, exp_desc);
    endtask

    task automatic advance_desc(input bit eor, input string req);
        desc_eor = eor;
        advance = 1'b1;
        fetch_req = 1'b1;
        tick();
        advance = 1'b0;
        fetch_req = 1'b0;
        desc_eor = 1'b0;
        if (eor) exp_desc = exp_base;
        else exp_desc = exp_desc + AW'(4*(exp_words + exp_skip));
        check(desc_addr == exp_desc, req, desc_addr, exp_desc);
        check(word_valid == 1'b0, "R9 advance wins over fetch", AW'(word_valid), 0);
    endtask

    task automatic stop_ring();
        run_en = 1'b0;
        tick();
    endtask

    task automatic test_contiguous();
        start_ring(32'h0000_1000, 0, 1'b0);
        fetch_desc(1'b0);
        advance_desc(1'b0, "R6 contiguous 16B step");
        fetch_desc(1'b0);
        advance_desc(1'b1, "R7 eor wrap to base");
        stop_ring();
        start_ring(32'h0000_4000, 0, 1'b1);
        advance_desc(1'b0, "R6 contiguous 32B step");
        stop_ring();
    endtask

    task automatic test_skip_and_shadow();
        start_ring(32'h0000_8000, 3, 1'b1);
        fetch_desc(1'b0);
        advance_desc(1'b0, "R5 skip step 8+3");
        cfg_base = 32'h0000_C000;
        cfg_skip = 5'd31;
        cfg_alt_size = 1'b0;
        tick();
        check(desc_addr == exp_desc, "R8 base change ignored", desc_addr, exp_desc);
        advance_desc(1'b0, "R8 skip change ignored");
        fetch_desc(1'b1);
        advance_desc(1'b1, "R8 wrap uses captured base");
        stop_ring();
    endtask

    task automatic test_wrap_modulo();
        start_ring(32'hFFFF_FFE0, 31, 1'b1);
        advance_desc(1'b0, "R11 modulo wrap");
        check(desc_addr == 32'h0000_007C, "R11 wrapped value", desc_addr, 32'h0000_007C);
        stop_ring();
    endtask

    task automatic test_abort();
        start_ring(32'h0000_2000, 1, 1'b1);
        fetch_req = 1'b1;
        tick();
        fetch_req = 1'b0;
        tick();
        check(word_valid == 1'b1, "R10 fetch running", AW'(word_valid), 1);
        cfg_base = 32'h0000_3001;
        run_en = 1'b0;
        tick();
        check(word_valid == 1'b0, "R10 stop clears valid", AW'(word_valid), 0);
        check(desc_addr == 32'h0000_3000, "R10 back to base tracking", desc_addr, 32'h0000_3000);
        tick();
        check(word_valid == 1'b0, "R10 stays idle", AW'(word_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_idle_track();
        test_contiguous();
        test_skip_and_shadow();
        test_wrap_modulo();
        test_abort();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule